// File: doc/BRIEF.md
# Edge-Triggered Interrupt Message Generator

This block sits between a set of application slaves that each drive a level interrupt line and the link core that sends message-signalled interrupts to the host. Each line is registered once and then checked for a low-to-high transition. When a transition is seen and the block is armed, the block raises a single message request toward the link core. That request stays up until the core acknowledges it.

A sticky status vector records every line that has been seen high. Host software reads this vector through the register interface to find out which sources fired, and clears bits by writing ones to them. Once the block has issued a message, it sends no further message until it has observed a cycle on which every input is low. For that reason software must clear all of its sources for each message it receives.

The whole interrupt function exists only when the register-access port is enabled by parameter. With that port disabled, both outputs are held at zero.

Top module: `ims_msi_gen`

## Requirements
- R1: During and after reset (active-low `rstN`), `msiReq` is 0, `statusOut` is all zeros, and the block is armed.
- R2: A 0-to-1 change on any `irqIn` bit asserts `msiReq` at the second rising clock edge after the change, provided the block is armed and no request is outstanding. A high pulse on an input that lasts only one cycle is still detected.
- R3: When a request is issued, the block becomes unarmed. It becomes armed again only after a clock edge at which the registered inputs are all 0. While it is unarmed, rising edges produce no request.
- R4: Once `msiReq` is 1, it stays 1 until `msiAck` is sampled at 1 on a clock edge, and it is 0 from that edge onward. Driving `msiAck` while no request is outstanding has no effect.
- R5: Bit i of `statusOut` is set at the second edge after `irqIn[i]` goes high. The bit stays set until it is cleared.
- R6: Holding `clearEn` at 1 during an edge clears each status bit whose `clearMask` bit is 1. Bits whose mask bit is 0 are left unchanged. If the input of a bit is still registered high at that edge, the bit stays set, because setting wins over clearing.
- R7: A rising edge that arrives while a request is outstanding sets its status bit. It does not cause a second request after the acknowledge.
- R8: When parameter `IRQ_ENABLE` is 0, `msiReq` and `statusOut` are constantly 0, whatever the inputs do.
- R9: Parameter `NUM_IRQ` (1 to 16) sets the input and status width. The highest bit behaves the same as bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IRQ | Level interrupt lines from application slaves |
| clearEn | input | 1 | Status write strobe (write-1-to-clear) |
| clearMask | input | NUM_IRQ | Bits to clear when clearEn is 1 |
| statusOut | output | NUM_IRQ | Sticky pending-source status for host reads |
| msiReq | output | 1 | Message request to the link core |
| msiAck | input | 1 | Acknowledge from the link core |

## Verification
The bench goes after several corner cases, each tied to a specific failure:
- A one-cycle pulse must still be detected. A design without the input register would sample the pulse inconsistently.
- Sources that overlap without all returning low must not re-arm the block. A design that rearms on any falling edge would send extra messages.
- An edge that arrives while a request is outstanding is the case a design that queues requests would get wrong, by producing a second message after the acknowledge.
- Clearing a status bit whose input is still high must leave the bit set. A design in which clearing wins would lose that source.
- Reset must drop an outstanding request, and bit 15 must behave like the low bits. A width or indexing slip would show up on that top bit.

// File: rtl/ims_pkg.sv
package ims_pkg;
  typedef struct packed {
    logic anyRise;
    logic allLow;
  } irqEvents_t;

  typedef enum logic {CS_IDLE = 1'b0, CS_PENDING = 1'b1} ctrlState_t;
endpackage

// File: rtl/ims_datapath.sv
module ims_datapath #(
  parameter int NUM_IRQ = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQ-1:0]  irqIn,
  input  logic                clearEn,
  input  logic [NUM_IRQ-1:0]  clearMask,
  output logic [NUM_IRQ-1:0]  statusQ,
  output ims_pkg::irqEvents_t events
);
  logic [NUM_IRQ-1:0] irqSync;
  logic [NUM_IRQ-1:0] irqPrev;
  logic [NUM_IRQ-1:0] riseVec;

  // one register stage on the lines, then a history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqSync <= '0;
      irqPrev <= '0;
    end else begin
      irqSync <= irqIn;
      irqPrev <= irqSync;
    end
  end

  assign riseVec = irqSync & ~irqPrev;

  // per-source sticky status, set has priority over the write-1 clear
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[g] <= 1'b0;
      end else begin
        statusQ[g] <= irqSync[g] | (statusQ[g] & ~(clearEn & clearMask[g]));
      end
    end
  end

  always_comb begin
    events.anyRise = |riseVec;
    events.allLow  = ~|irqSync;
  end
endmodule

// File: rtl/ims_control.sv
module ims_control (
  input  logic                clk,
  input  logic                rstN,
  input  ims_pkg::irqEvents_t events,
  input  logic                msiAck,
  output logic                msiReq
);
  import ims_pkg::*;

  ctrlState_t stateQ, stateD;
  logic       armedQ, armedD;
  logic       issue;

  always_comb begin
    issue  = armedQ && events.anyRise && (stateQ == CS_IDLE);
    stateD = stateQ;
    armedD = armedQ;
    case (stateQ)
      CS_IDLE:    if (issue)  stateD = CS_PENDING;
      CS_PENDING: if (msiAck) stateD = CS_IDLE;
      default:    stateD = CS_IDLE;
    endcase
    if (issue) begin
      armedD = 1'b0;
    end else if (events.allLow) begin
      armedD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= CS_IDLE;
      armedQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      armedQ <= armedD;
    end
  end

  assign msiReq = (stateQ == CS_PENDING);
endmodule

// File: rtl/ims_msi_gen.sv
module ims_msi_gen #(
  parameter int NUM_IRQ    = 16,
  parameter bit IRQ_ENABLE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               clearEn,
  input  logic [NUM_IRQ-1:0] clearMask,
  output logic [NUM_IRQ-1:0] statusOut,
  output logic               msiReq,
  input  logic               msiAck
);
  if (IRQ_ENABLE) begin : g_on
    ims_pkg::irqEvents_t events;

    ims_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
      .clk       (clk),
      .rstN      (rstN),
      .irqIn     (irqIn),
      .clearEn   (clearEn),
      .clearMask (clearMask),
      .statusQ   (statusOut),
      .events    (events)
    );

    ims_control u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .events (events),
      .msiAck (msiAck),
      .msiReq (msiReq)
    );
  end else begin : g_off
    assign statusOut = '0;
    assign msiReq    = 1'b0;
  end
endmodule

// File: rtl/ims_checker.sv
module ims_checker #(
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               clearEn,
  input logic [NUM_IRQ-1:0] statusOut,
  input logic               msiReq,
  input logic               msiAck
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (msiReq && !msiAck) |=> msiReq); // R4

  AST_REQ_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (msiReq && msiAck) |=> !msiReq); // R4

  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msiReq) |-> (statusOut != '0)); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clearEn |=> ((statusOut & $past(statusOut)) == $past(statusOut))); // R5
endmodule

bind ims_msi_gen ims_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearEn   (clearEn),
  .statusOut (statusOut),
  .msiReq    (msiReq),
  .msiAck    (msiAck)
);

// File: tb/tb_ims_msi_gen.sv
module tb_ims_msi_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 16;
  localparam int NVEC = 20;

  typedef struct packed {
    logic [15:0] irq;
    logic        ack;
    logic        clr;
    logic [15:0] mask;
    logic        expReq;
    logic [15:0] expStat;
  } vec_t;

  // each row: drive at a falling edge, check after the next rising edge
  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0001}, // R2 edge issues
    '{16'h0003, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0001},
    '{16'h0003, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0003}, // R4 ack retires, R7 edge during pending
    '{16'h0002, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0003},
    '{16'h0006, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0003},
    '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0007}, // R3 edge while unarmed
    '{16'h0000, 1'b0, 1'b1, 16'h0007, 1'b0, 16'h0000}, // R6 clear, all low rearms
    '{16'h0008, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0008}, // R2 one-cycle pulse
    '{16'h0000, 1'b0, 1'b1, 16'h0008, 1'b1, 16'h0000},
    '{16'h0004, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    '{16'h0004, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0004}, // R7
    '{16'h0004, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0004},
    '{16'h0004, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0004}, // R7 no queued message
    '{16'h0004, 1'b0, 1'b1, 16'h0004, 1'b0, 16'h0004}, // R6 set wins
    '{16'h0000, 1'b0, 1'b1, 16'h0004, 1'b0, 16'h0004},
    '{16'h0000, 1'b0, 1'b1, 16'h0004, 1'b0, 16'h0000},
    '{16'h8000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{16'h8000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h8000}  // R9 top bit
  };

  logic            clk = 1'b0;
  logic            rstN;
  logic [NIRQ-1:0] irqIn;
  logic            clearEn;
  logic [NIRQ-1:0] clearMask;
  logic [NIRQ-1:0] statusOut;
  logic            msiReq;
  logic            msiAck;
  logic [NIRQ-1:0] statusOff;
  logic            msiReqOff;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ims_msi_gen #(.NUM_IRQ(NIRQ), .IRQ_ENABLE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .clearEn(clearEn),
    .clearMask(clearMask), .statusOut(statusOut), .msiReq(msiReq), .msiAck(msiAck)
  );

  ims_msi_gen #(.NUM_IRQ(NIRQ), .IRQ_ENABLE(1'b0)) dutOff (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .clearEn(clearEn),
    .clearMask(clearMask), .statusOut(statusOff), .msiReq(msiReqOff), .msiAck(msiAck)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0; clearEn = 1'b0; clearMask = '0; msiAck = 1'b0;
    step(3);
    check("R1 reset msiReq", {31'd0, msiReq}, 32'd0);
    check("R1 reset status", {16'd0, statusOut}, 32'd0);
    rstN = 1'b1;
    step(2);

    for (int i = 0; i < NVEC; i++) begin
      irqIn = VECS[i].irq; msiAck = VECS[i].ack;
      clearEn = VECS[i].clr; clearMask = VECS[i].mask;
      step(1);
      check($sformatf("R2/R3/R4/R7 req row %0d", i), {31'd0, msiReq}, {31'd0, VECS[i].expReq});
      check($sformatf("R5/R6/R9 status row %0d", i), {16'd0, statusOut}, {16'd0, VECS[i].expStat});
      check($sformatf("R8 disabled outputs row %0d", i), {15'd0, msiReqOff, statusOff}, 32'd0);
    end

    // retire the bit-15 request
    msiAck = 1'b1; clearEn = 1'b0; step(1); msiAck = 1'b0;
    check("R4 ack retires top-bit request", {31'd0, msiReq}, 32'd0);
    // lines low rearm, then clear status
    irqIn = '0; step(2);
    clearEn = 1'b1; clearMask = 16'h8000; step(1); clearEn = 1'b0;
    check("R6 top bit cleared", {16'd0, statusOut}, 32'd0);
    // ack without a request has no effect
    msiAck = 1'b1; step(3);
    check("R4 stray ack no request", {31'd0, msiReq}, 32'd0);
    msiAck = 1'b0;
    // armed again: new edge issues
    irqIn = 16'h0010; step(1);
    check("R2 not yet after one edge", {31'd0, msiReq}, 32'd0);
    step(1);
    check("R2 request after rearm", {31'd0, msiReq}, 32'd1);
    step(3);
    check("R4 request held without ack", {31'd0, msiReq}, 32'd1);
    // reset drops pending request and status
    rstN = 1'b0; step(1);
    check("R1 reset drops request", {31'd0, msiReq}, 32'd0);
    check("R1 reset clears status", {16'd0, statusOut}, 32'd0);
    irqIn = '0; step(1); rstN = 1'b1; step(2);
    // armed after reset
    irqIn = 16'h0001; step(2);
    check("R1 armed after reset", {31'd0, msiReq}, 32'd1);
    check("R8 disabled after run", {15'd0, msiReqOff, statusOff}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule